// File: doc/BRIEF.md
# Predicated Vector-Loop Add Sequencer

This block turns a single scalar-form add into a loop over a run of elements held in a small integer register file. A start pulse supplies the loop length, a destination and two source register numbers, the number of the register that holds the predicate mask, and one flag per operand saying whether that operand is a vector. The block then works through one element per clock cycle. For each element it tests one mask bit. When that bit is set, it adds the two selected source registers and writes the sum to the selected destination register. After every element it moves each vector operand on to the next register. A scalar operand stays on its base register, so the one opcode covers the scalar-scalar, scalar-vector and vector-vector forms.

The register file sits inside the block. It has 32 registers of 64 bits and no special register zero. While the sequencer is idle, a host port can load and inspect the registers. A one-cycle done pulse marks the end of each operation.

Top module: `vadd_seq`

## Requirements
- R1: An accepted start with length VL > 0 keeps busy high for exactly VL cycles, one element per cycle. Done is a single-cycle pulse in the cycle after the last element, and busy is low by then.
- R2: A start with VL = 0 writes no register and never raises busy. Done pulses in the cycle after the start edge.
- R3: Element i (i counted from 0) writes its destination only when bit i of the mask is 1. A masked-off element leaves every register unchanged.
- R4: The value written is (R[rs1 + o1] + R[rs2 + o2]) modulo 2^64, at full register width, and it goes to R[rd + od], where o1, o2 and od are the current operand offsets.
- R5: Every offset starts at 0. After each element, an operand flagged as vector advances its offset by 1, whether or not the mask bit was set. A scalar operand keeps offset 0.
- R6: Register number plus offset wraps modulo 32.
- R7: The mask is the value of the predicate register at the start edge. A write to that register during the loop does not change which later elements are written.
- R8: A start pulse while busy is high is ignored and does not change the running operation.
- R9: Register 0 reads and writes like any other register.
- R10: All registers reset to zero. While idle, a host write stores data at the addressed register, and the host read data shows the addressed register combinationally.
- R11: Elements are processed in index order. A read in element i sees the writes made by elements before i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| vecLen | input | 7 | Number of elements, 0 to 64 |
| dstReg | input | 5 | Destination base register |
| srcAReg | input | 5 | First source base register |
| srcBReg | input | 5 | Second source base register |
| predReg | input | 5 | Register holding the predicate mask |
| dstVec | input | 1 | Destination is a vector |
| srcAVec | input | 1 | First source is a vector |
| srcBVec | input | 1 | Second source is a vector |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| hostWe | input | 1 | Host register write enable (idle only) |
| hostWrAddr | input | 5 | Host write address |
| hostWrData | input | 64 | Host write data |
| hostRdAddr | input | 5 | Host read address |
| hostRdData | output | 64 | Host read data |

## Verification
The hardest case to reach from the ports is a loop that overwrites its own predicate register, or reads a register that an earlier element has just written. The stimulus gets there by choosing the destination run so that it covers the predicate register or the next source element. The register file is then compared against a sequential reference loop, so a mask that is re-read, or a write that lands out of order, shows up as a wrong register. A second start pulse in the middle of a loop, and runs that wrap past register 31, are forced in the same way. The bench sweeps all eight vector-flag combinations with random masks.

// File: rtl/vadd_seq_pkg.sv
package vadd_seq_pkg;
  typedef struct packed {
    logic active;   // loop running
    logic load;     // capture operands and mask, clear offsets
    logic step;     // process one element this cycle
  } seqStrobe_t;
endpackage

// File: rtl/vadd_seq_ctrl.sv
module vadd_seq_ctrl
  import vadd_seq_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [VL_W-1:0] vecLen,
  output seqStrobe_t      strobe,
  output logic [VL_W-1:0] elemIdx,
  output logic            done
);
  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t       stateQ;
  logic [VL_W-1:0] lenQ;
  logic [VL_W-1:0] idxQ;
  logic            doneQ;
  logic            lastElem;

  assign lastElem = (idxQ == lenQ - VL_W'(1));

  always_comb begin
    strobe.active = (stateQ == ST_RUN);
    strobe.load   = (stateQ == ST_IDLE) && start;
    strobe.step   = (stateQ == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      lenQ   <= '0;
      idxQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            lenQ <= vecLen;
            idxQ <= '0;
            if (vecLen == '0) doneQ  <= 1'b1;
            else              stateQ <= ST_RUN;
          end
        end
        ST_RUN: begin
          idxQ <= idxQ + VL_W'(1);
          if (lastElem) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign elemIdx = idxQ;
  assign done    = doneQ;

  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && vecLen == '0) |=> (doneQ && stateQ == ST_IDLE)) else $error("zero length"); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ) else $error("done width"); // R1
  AST_RUN_ENDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.active) |-> doneQ) else $error("end without done"); // R1
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && start) |=> $stable(lenQ)) else $error("restart while busy"); // R8
endmodule

// File: rtl/vadd_seq_datapath.sv
module vadd_seq_datapath
  import vadd_seq_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int XLEN     = 64,
  parameter int VL_W     = 7,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int NUM_OPS = 3,
  localparam int MIDX_W  = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [VL_W-1:0]  elemIdx,
  input  logic [REG_W-1:0] dstReg,
  input  logic [REG_W-1:0] srcAReg,
  input  logic [REG_W-1:0] srcBReg,
  input  logic [REG_W-1:0] predReg,
  input  logic             dstVec,
  input  logic             srcAVec,
  input  logic             srcBVec,
  input  logic             hostWe,
  input  logic [REG_W-1:0] hostWrAddr,
  input  logic [XLEN-1:0]  hostWrData,
  input  logic [REG_W-1:0] hostRdAddr,
  output logic [XLEN-1:0]  hostRdData
);
  // operand 0 = destination, 1 = first source, 2 = second source
  logic [XLEN-1:0]  regFile [NUM_REGS];
  logic [XLEN-1:0]  maskQ;
  logic [REG_W-1:0] baseIn [NUM_OPS];
  logic             vecIn  [NUM_OPS];
  logic [REG_W-1:0] effAddr [NUM_OPS];

  assign baseIn[0] = dstReg;
  assign baseIn[1] = srcAReg;
  assign baseIn[2] = srcBReg;
  assign vecIn[0]  = dstVec;
  assign vecIn[1]  = srcAVec;
  assign vecIn[2]  = srcBVec;

  for (genvar g = 0; g < NUM_OPS; g++) begin : gOperand
    logic [REG_W-1:0] baseQ;
    logic [REG_W-1:0] offQ;
    logic             vecQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        offQ  <= '0;
        vecQ  <= 1'b0;
      end else if (strobe.load) begin
        baseQ <= baseIn[g];
        offQ  <= '0;
        vecQ  <= vecIn[g];
      end else if (strobe.step && vecQ) begin
        offQ <= offQ + REG_W'(1);
      end
    end

    assign effAddr[g] = baseQ + offQ;

    AST_SCALAR_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.step && !vecQ) |-> (offQ == '0)) else $error("scalar offset moved"); // R5
    AST_VECTOR_OFFSET_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.step && vecQ) |-> (offQ == elemIdx[REG_W-1:0])) else $error("vector offset lost"); // R5
  end

  // read ports
  logic [REG_W-1:0] rdAddrA;
  logic [XLEN-1:0]  rdDataA;
  logic [XLEN-1:0]  rdDataB;

  always_comb begin
    if (strobe.active)    rdAddrA = effAddr[1];
    else if (strobe.load) rdAddrA = predReg;
    else                  rdAddrA = hostRdAddr;
  end

  assign rdDataA    = regFile[rdAddrA];
  assign rdDataB    = regFile[effAddr[2]];
  assign hostRdData = rdDataA;

  // write port
  logic             elemWe;
  logic             wrEn;
  logic [REG_W-1:0] wrAddr;
  logic [XLEN-1:0]  wrData;

  assign elemWe = strobe.step && maskQ[elemIdx[MIDX_W-1:0]];

  always_comb begin
    if (strobe.active) begin
      wrEn   = elemWe;
      wrAddr = effAddr[0];
      wrData = rdDataA + rdDataB;
    end else begin
      wrEn   = hostWe && !strobe.load;
      wrAddr = hostWrAddr;
      wrData = hostWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regFile[r] <= '0;
    end else if (wrEn) begin
      regFile[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strobe.load) maskQ <= rdDataA;
  end

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> $stable(maskQ)) else $error("mask changed in loop"); // R7
  AST_NO_HOST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && !elemWe) |=> $stable(regFile[$past(hostWrAddr)])) else $error("write while masked"); // R3
endmodule

// File: rtl/vadd_seq.sv
module vadd_seq
  import vadd_seq_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int XLEN     = 64,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int VL_W    = $clog2(XLEN) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [REG_W-1:0] dstReg,
  input  logic [REG_W-1:0] srcAReg,
  input  logic [REG_W-1:0] srcBReg,
  input  logic [REG_W-1:0] predReg,
  input  logic             dstVec,
  input  logic             srcAVec,
  input  logic             srcBVec,
  output logic             busy,
  output logic             done,
  input  logic             hostWe,
  input  logic [REG_W-1:0] hostWrAddr,
  input  logic [XLEN-1:0]  hostWrData,
  input  logic [REG_W-1:0] hostRdAddr,
  output logic [XLEN-1:0]  hostRdData
);
  seqStrobe_t      strobe;
  logic [VL_W-1:0] elemIdx;

  vadd_seq_ctrl #(.VL_W(VL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .strobe(strobe), .elemIdx(elemIdx), .done(done)
  );

  vadd_seq_datapath #(.NUM_REGS(NUM_REGS), .XLEN(XLEN), .VL_W(VL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .elemIdx(elemIdx),
    .dstReg(dstReg), .srcAReg(srcAReg), .srcBReg(srcBReg), .predReg(predReg),
    .dstVec(dstVec), .srcAVec(srcAVec), .srcBVec(srcBVec),
    .hostWe(hostWe), .hostWrAddr(hostWrAddr), .hostWrData(hostWrData),
    .hostRdAddr(hostRdAddr), .hostRdData(hostRdData)
  );

  assign busy = strobe.active;
endmodule

// File: tb/vadd_seq_tb_top.sv
module vadd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vecLen = '0;
  logic [4:0]  dstReg = '0, srcAReg = '0, srcBReg = '0, predReg = '0;
  logic        dstVec = 1'b0, srcAVec = 1'b0, srcBVec = 1'b0;
  logic        busy, done;
  logic        hostWe = 1'b0;
  logic [4:0]  hostWrAddr = '0, hostRdAddr = '0;
  logic [63:0] hostWrData = '0;
  logic [63:0] hostRdData;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [32];

  always #5 clk = ~clk;

  vadd_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .dstReg(dstReg), .srcAReg(srcAReg), .srcBReg(srcBReg), .predReg(predReg),
    .dstVec(dstVec), .srcAVec(srcAVec), .srcBVec(srcBVec),
    .busy(busy), .done(done),
    .hostWe(hostWe), .hostWrAddr(hostWrAddr), .hostWrData(hostWrData),
    .hostRdAddr(hostRdAddr), .hostRdData(hostRdData)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostWrAddr = a; hostWrData = d;
    @(negedge clk);
    hostWe = 1'b0;
    model[a] = d;
  endtask

  task automatic fillRandom();
    for (int r = 0; r < 32; r++) hostWrite(5'(r), {$urandom, $urandom});
  endtask

  task automatic compareAll(input string req);
    @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      hostRdAddr = 5'(r);
      #1;
      check(req, $sformatf("reg %0d", r), hostRdData, model[r]);
    end
  endtask

  // sequential reference of the predicated loop
  task automatic modelLoop(input int vl, input logic [4:0] rd, input logic [4:0] ra,
                           input logic [4:0] rb, input logic [4:0] rp,
                           input bit vd, input bit va, input bit vb);
    logic [63:0] mask;
    logic [4:0] od, oa, ob;
    mask = model[rp];
    od = '0; oa = '0; ob = '0;
    for (int i = 0; i < vl; i++) begin
      if (mask[i]) model[5'(rd + od)] = model[5'(ra + oa)] + model[5'(rb + ob)];
      if (vd) od = od + 5'd1;
      if (va) oa = oa + 5'd1;
      if (vb) ob = ob + 5'd1;
    end
  endtask

  task automatic runOp(input string req, input int vl, input logic [4:0] rd, input logic [4:0] ra,
                       input logic [4:0] rb, input logic [4:0] rp,
                       input bit vd, input bit va, input bit vb, input bit midStart);
    int cyc;
    int busyCyc;
    modelLoop(vl, rd, ra, rb, rp, vd, va, vb);
    @(negedge clk);
    start = 1'b1; vecLen = 7'(vl);
    dstReg = rd; srcAReg = ra; srcBReg = rb; predReg = rp;
    dstVec = vd; srcAVec = va; srcBVec = vb;
    cyc = 0; busyCyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (midStart && cyc == 2) begin
        // R8: second start with other operands while busy
        start = 1'b1; vecLen = 7'd3; dstReg = 5'd1; srcAReg = 5'd2; srcBReg = 5'd3;
        predReg = 5'd4; dstVec = 1'b1; srcAVec = 1'b1; srcBVec = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (busy) busyCyc++;
      if (done || cyc > 200) break;
    end
    start = 1'b0;
    check(vl == 0 ? "R2" : "R1", "done cycle", 64'(cyc), 64'(vl + 1));
    check(vl == 0 ? "R2" : "R1", "busy cycles", 64'(busyCyc), 64'(vl));
    check("R1", "busy low at done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check("R1", "done single pulse", {63'd0, done}, 64'd0);
    compareAll(req);
  endtask

  task automatic testReset();
    check("R10", "busy after reset", {63'd0, busy}, 64'd0);
    check("R10", "done after reset", {63'd0, done}, 64'd0);
    for (int r = 0; r < 32; r++) model[r] = '0;
    compareAll("R10");
    hostWrite(5'd7, 64'hDEAD_BEEF_0123_4567);
    compareAll("R10");
  endtask

  task automatic testFlagCombos();
    for (int f = 0; f < 8; f++) begin
      fillRandom();
      hostWrite(5'd28, {$urandom, $urandom});
      // R3 R4 R5: every vector-flag combination with a random mask
      runOp("R3/R4/R5", 8, 5'd4, 5'd12, 5'd20, 5'd28, f[0], f[1], f[2], 1'b0);
    end
  endtask

  task automatic testWrap();
    fillRandom();
    hostWrite(5'd10, 64'h3F);
    runOp("R6", 6, 5'd30, 5'd29, 5'd31, 5'd10, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testZeroLen();
    fillRandom();
    runOp("R2", 0, 5'd3, 5'd4, 5'd5, 5'd6, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testMaskCapture();
    fillRandom();
    // R7: element 0 overwrites the predicate register, mask 0b1011
    hostWrite(5'd5, 64'hB);
    hostWrite(5'd8, 64'hFFFF_FFFF_FFFF_FFF0);
    hostWrite(5'd9, 64'h4);
    runOp("R7", 4, 5'd5, 5'd8, 5'd9, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testBusyStart();
    fillRandom();
    hostWrite(5'd16, 64'hFF);
    runOp("R8", 6, 5'd20, 5'd8, 5'd0, 5'd16, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testRegZero();
    fillRandom();
    hostWrite(5'd0, 64'h1234);
    hostWrite(5'd3, 64'h1);
    runOp("R9", 3, 5'd0, 5'd0, 5'd6, 5'd3, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testChainFull();
    fillRandom();
    hostWrite(5'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    hostWrite(5'd2, 64'd1);
    hostWrite(5'd31, 64'd5);
    // R11: each element reads the previous element's result (rd = rs1 + 1), 64 elements
    runOp("R11", 64, 5'd3, 5'd2, 5'd31, 5'd1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFlagCombos();
    testWrap();
    testZeroLen();
    testMaskCapture();
    testBusyStart();
    testRegZero();
    testChainFull();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule